// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

This block controls a parameterised bidirectional I/O port (eight pins by default) through a small register bus with separate read and write strobes. Software sets a direction bit per pin, loads an output latch, and reads the pin levels after a two-stage synchronizer. For every pin the block drives the pad controls: an output enable, an output value and a weak pull-up enable. One active-low control bit switches all pull-ups on at once. A pin's pull-up is always off while that pin drives.

The upper half of the port (bits 7 to 4 by default) can raise an interrupt when a pin changes. Each of those bits that is an input is compared with a snapshot of the pins. The snapshot is taken whenever software reads or writes the port register, so it is not simply the previous clock's sample. Any difference sets a sticky flag, which drives the interrupt output. A mismatch that is still present keeps setting the flag, so software must access the port before it can clear the flag. The block also exposes a wake request for power control. A low-voltage-programming mode input forces the pull-up of bit 5 off.

Register addresses: 0 port, 1 output latch, 2 direction, 3 control (bit 0 is the pull-up disable, where 1 means the pull-ups are off), 4 change flag (bit 0).

Top module: `gpio_chg_port`

## Requirements
- R1: A direction bit of 1 puts the pin in input mode (pin_oe low). A direction bit of 0 raises pin_oe, and pin_out carries the latch bit. Direction is at address 2.
- R2: A write to address 1 loads the output latch. A read of address 1 returns the latch contents, whatever the pin levels are.
- R3: A read of address 0 returns the pin levels as they were two clock edges earlier, taken through the synchronizer.
- R4: pin_pu[i] is high only when control bit 0 (address 3) is 0 and direction bit i is 1.
- R5: After reset the direction is 0xFF, the latch is 0x00, control bit 0 is 1, the flag is 0 and the snapshot is 0x00.
- R6: Only bits 7 to 4 can set the flag, and only while they are configured as inputs. Changes on bits 3 to 0, and on upper bits that are outputs, do not set it.
- R7: An eligible input that differs from the snapshot sets the flag (address 4 bit 0, also the chg_irq output). While the mismatch remains, writing 0 to address 4 leaves the flag set, because the set wins.
- R8: A read or write of address 0 copies the synchronized pins into the snapshot. After that, writing 0 to address 4 clears the flag. Writing 1 to address 4 has no effect.
- R9: wake_req is high whenever the flag is set.
- R10: While lvp_mode is high, pin_pu[5] is low, even when the global pull-up enable is active.
- R11: A write to address 0 also loads the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (port reads take a snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_oe | output | 8 | Pad output enable per pin |
| pin_out | output | 8 | Pad output value per pin |
| pin_pu | output | 8 | Weak pull-up enable per pin |
| lvp_mode | input | 1 | Low-voltage programming mode; turns bit 5 pull-up off |
| chg_irq | output | 1 | Change interrupt (sticky flag) |
| wake_req | output | 1 | Wake request from the change logic |

## Verification
Random sequences mix pin toggles across all eight bits with random direction and latch values. This separates the upper eligible bits from the lower ones, and input bits from output bits, in the change comparison. Directed cases make a change on an upper input and then try to clear the flag without a port access, which shows that the flag follows the snapshot and not the previous sample. The same cases then read the port and clear the flag, and check that the clear now works. Further directed cases toggle only the lower pins or only an upper output pin, which must leave the flag alone. Separate cases turn the pull-ups on with lvp_mode high and low, which shows whether bit 5 is forced off.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      SEL_PORT = 3'd0,
      SEL_LAT  = 3'd1,
      SEL_DIR  = 3'd2,
      SEL_CTRL = 3'd3,
      SEL_FLAG = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_chg_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= '0;
         else if (s == 0)
            stage_q[s] <= d_in;
         else
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
   import gpio_chg_pkg::*;
#(
   parameter int W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [W-1:0]      wdata,
   input  logic [W-1:0]      pins_sync,
   input  logic              flag,
   output logic [W-1:0]      rdata,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      lat_q,
   output logic              pull_off_q,
   output logic              port_touch,
   output logic              flag_clr
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q      <= '1;
         lat_q      <= '0;
         pull_off_q <= 1'b1;
      end else if (wr) begin
         case (sel)
            SEL_PORT, SEL_LAT: lat_q      <= wdata;
            SEL_DIR:           dir_q      <= wdata;
            SEL_CTRL:          pull_off_q <= wdata[0];
            default:           ;
         endcase
      end
   end

   assign port_touch = (wr || rd) && (sel == SEL_PORT);
   assign flag_clr   = wr && (sel == SEL_FLAG) && !wdata[0];

   always_comb begin
      case (sel)
         SEL_PORT: rdata = pins_sync;
         SEL_LAT:  rdata = lat_q;
         SEL_DIR:  rdata = dir_q;
         SEL_CTRL: rdata = {{(W-1){1'b0}}, pull_off_q};
         SEL_FLAG: rdata = {{(W-1){1'b0}}, flag};
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
   parameter int W      = 8,
   parameter int CHG_LO = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins_sync,
   input  logic [W-1:0] dir_q,
   input  logic         port_touch,
   input  logic         flag_clr,
   output logic         flag_q,
   output logic         mismatch
);
   if (CHG_LO < 0 || CHG_LO >= W) begin : g_bad_lo
      $error("gpio_chg_detect: CHG_LO out of range");
   end

   logic [W-1:0] snap_q;
   logic [W-1:0] eligible;

   for (genvar b = 0; b < W; b++) begin : g_elig
      if (b >= CHG_LO) begin : g_on
         assign eligible[b] = dir_q[b] & (pins_sync[b] ^ snap_q[b]);
      end else begin : g_off
         assign eligible[b] = 1'b0;
      end
   end

   assign mismatch = |eligible;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (port_touch)
            snap_q <= pins_sync;
         if (mismatch)
            flag_q <= 1'b1;
         else if (flag_clr)
            flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/gpio_chg_pad.sv
module gpio_chg_pad #(
   parameter int W       = 8,
   parameter int LVP_BIT = 5
) (
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] lat_q,
   input  logic         pull_off_q,
   input  logic         lvp_mode,
   output logic [W-1:0] oe,
   output logic [W-1:0] dout,
   output logic [W-1:0] pu
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign oe[b]   = ~dir_q[b];
      assign dout[b] = lat_q[b];
      if (b == LVP_BIT) begin : g_lvp
         assign pu[b] = ~pull_off_q & dir_q[b] & ~lvp_mode;
      end else begin : g_norm
         assign pu[b] = ~pull_off_q & dir_q[b];
      end
   end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
   import gpio_chg_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int CHG_LO      = 4,
   parameter int LVP_BIT     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_pu,
   input  logic              lvp_mode,
   output logic              chg_irq,
   output logic              wake_req
);
   if (LVP_BIT >= PORT_W) begin : g_bad_lvp
      $error("gpio_chg_port: LVP_BIT outside the port");
   end

   logic [PORT_W-1:0] pins_sync, dir_q, lat_q;
   logic              pull_off_q, port_touch, flag_clr, flag_q, mismatch;

   gpio_chg_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_sync(pins_sync));

   gpio_chg_regs #(.W(PORT_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .pins_sync(pins_sync), .flag(flag_q),
      .rdata(bus_rdata), .dir_q(dir_q), .lat_q(lat_q),
      .pull_off_q(pull_off_q), .port_touch(port_touch), .flag_clr(flag_clr));

   gpio_chg_detect #(.W(PORT_W), .CHG_LO(CHG_LO)) i_detect (
      .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .dir_q(dir_q),
      .port_touch(port_touch), .flag_clr(flag_clr),
      .flag_q(flag_q), .mismatch(mismatch));

   gpio_chg_pad #(.W(PORT_W), .LVP_BIT(LVP_BIT)) i_pad (
      .dir_q(dir_q), .lat_q(lat_q), .pull_off_q(pull_off_q),
      .lvp_mode(lvp_mode), .oe(pin_oe), .dout(pin_out), .pu(pin_pu));

   assign chg_irq  = flag_q;
   assign wake_req = flag_q | mismatch;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
   parameter int W       = 8,
   parameter int LVP_BIT = 5
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   bus_addr,
   input logic         bus_wr,
   input logic [W-1:0] bus_wdata,
   input logic [W-1:0] pin_oe,
   input logic [W-1:0] pin_out,
   input logic [W-1:0] pin_pu,
   input logic         lvp_mode,
   input logic         chg_irq,
   input logic         wake_req
);
   // R1
   p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd2) |=> (pin_oe == ~$past(bus_wdata)));

   // R2
   p_lat_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1) |=> (pin_out == $past(bus_wdata)));

   // R4
   p_no_pull_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & pin_oe) == '0);

   // R10
   p_lvp_pull_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lvp_mode |-> !pin_pu[LVP_BIT]);

   // R8
   p_flag_fall_by_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chg_irq) |-> $past(bus_wr && bus_addr == 3'd4 && !bus_wdata[0]));

   // R9
   p_irq_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chg_irq |-> wake_req);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(PORT_W), .LVP_BIT(LVP_BIT)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
   .lvp_mode(lvp_mode), .chg_irq(chg_irq), .wake_req(wake_req));

// File: tb/test_gpio_chg_port.sv
module test_gpio_chg_port;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] pin_in = '0, pin_oe, pin_out, pin_pu;
   logic       lvp_mode = 1'b0, chg_irq, wake_req;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0] m_dir = 8'hFF, m_lat = 8'h00, m_snap = 8'h00;
   logic       m_poff = 1'b1, m_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_chg_port i_gpio_chg_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
      .lvp_mode(lvp_mode), .chg_irq(chg_irq), .wake_req(wake_req));

   function automatic logic mism();
      return (((pin_in ^ m_snap) & m_dir & 8'hF0) != 8'h00);
   endfunction

   function automatic logic [7:0] exp_pu();
      logic [7:0] p;
      p = m_poff ? 8'h00 : m_dir;
      if (lvp_mode) p[5] = 1'b0;
      return p;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
      m_flag = m_flag | mism();
   endtask

   task automatic bus_write(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         3'd0: begin m_lat = d; m_snap = pin_in; end
         3'd1: m_lat = d;
         3'd2: m_dir = d;
         3'd3: m_poff = d[0];
         3'd4: if (!d[0]) m_flag = mism();
         default: ;
      endcase
   endtask

   task automatic bus_read(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #(CLK_PERIOD/4) d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      if (a == 3'd0) m_snap = pin_in;
   endtask

   task automatic check_all();
      logic [7:0] d;
      chk("R1 oe", pin_oe, ~m_dir);
      chk("R1 out", pin_out, m_lat);
      chk("R4/R10 pu", pin_pu, exp_pu());
      chk("R7 irq", {7'd0, chg_irq}, {7'd0, m_flag});
      if (m_flag) chk("R9 wake", {7'd0, wake_req}, 8'd1);
      bus_read(3'd1, d); chk("R2 latch read", d, m_lat);
      bus_read(3'd2, d); chk("R1 dir read", d, m_dir);
      bus_read(3'd4, d); chk("R7 flag read", d, {7'd0, m_flag});
   endtask

   initial begin
      repeat (2000 * 20) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state
      chk("R5 oe", pin_oe, 8'h00);
      chk("R5 pu", pin_pu, 8'h00);
      chk("R5 out", pin_out, 8'h00);
      chk("R5 irq", {7'd0, chg_irq}, 8'd0);
      bus_read(3'd3, d); chk("R5 ctrl", d, 8'h01);

      // R3 port read through synchronizer
      pin_in = 8'h0A; settle();
      bus_read(3'd0, d); chk("R3 port read", d, 8'h0A);
      chk("R6 low bits no flag", {7'd0, chg_irq}, 8'd0);

      // R7 sticky flag and ineffective clear
      pin_in = 8'h4A; settle();
      chk("R7 set", {7'd0, chg_irq}, 8'd1);
      bus_write(3'd4, 8'h00); settle();
      chk("R7 clear blocked", {7'd0, chg_irq}, 8'd1);
      bus_write(3'd4, 8'h01); settle();
      chk("R8 write one ignored", {7'd0, chg_irq}, 8'd1);
      // R8 port read, then clear works
      bus_read(3'd0, d);
      bus_write(3'd4, 8'h00); settle();
      chk("R8 cleared", {7'd0, chg_irq}, 8'd0);

      // R6 upper output bit excluded
      bus_write(3'd2, 8'h7F); settle();
      pin_in = 8'hCA; settle();
      chk("R6 output excluded", {7'd0, chg_irq}, 8'd0);

      // R11 port write loads latch
      bus_write(3'd0, 8'h5C); settle();
      chk("R11 latch via port", pin_out, 8'h5C);
      bus_read(3'd1, d); chk("R11 latch read", d, 8'h5C);

      // R10 lvp with pull-ups on
      bus_write(3'd2, 8'hFF); bus_write(3'd3, 8'h00);
      bus_read(3'd0, d); bus_write(3'd4, 8'h00); settle();
      chk("R4 pull all", pin_pu, 8'hFF);
      @(negedge clk) lvp_mode = 1'b1; settle();
      chk("R10 lvp", pin_pu, 8'hDF);
      @(negedge clk) lvp_mode = 1'b0; settle();
      check_all();

      // random mix
      for (int i = 0; i < 300; i++) begin
         int op;
         op = $urandom_range(0, 6);
         case (op)
            0: bus_write(3'd2, 8'($urandom));
            1: bus_write(3'd1, 8'($urandom));
            2: bus_write(3'd3, 8'($urandom));
            3: begin @(negedge clk); pin_in = 8'($urandom); end
            4: begin
                  logic [7:0] exp_port;
                  exp_port = pin_in;
                  bus_read(3'd0, d);
                  chk("R3 random port read", d, exp_port);
               end
            5: bus_write(3'd4, 8'($urandom_range(0, 1)));
            default: begin @(negedge clk); lvp_mode = 1'($urandom); end
         endcase
         settle();
         check_all();
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule